// File: doc/BRIEF.md
# One-Hot Cycle Timer with Masked-Term Control Decode

This block times each instruction and turns the current opcode and cycle into control lines. A single active bit walks through a shift register, one position per clock, to mark which cycle of the current instruction is in progress. An opcode register is loaded with a strobe, and the same strobe restarts the walk at the first cycle. An end strobe sends the token back to the first cycle and leaves the opcode in place.

The decode stage is a flat list of product terms. Each term compares the opcode against a value under a bit mask, so it can ignore any opcode bits. It also tests the live cycle against a cycle mask. Several terms can fire in the same clock. A routing matrix assigns each term one or more control outputs, and each output is the OR of every fired term routed to it. The term list and the routing are parameters, so the same block serves any encoding.

If an instruction runs past the last cycle without an end strobe, the token stays on the last cycle and a sticky overrun flag is raised. Control outputs stay low from reset until the first opcode load.

Top module: `cycle_pla_decoder`

## Requirements
- R1: After reset, `cycle_vec` equals 1 (only bit 0 set, meaning state 0) and `overrun` is 0. `ctrl_out` is 0 and stays 0 until the first `op_load`. Before that first load, `instr_end` has no effect and the token does not move.
- R2: `cycle_vec` always has exactly one bit set. Bit i set means the instruction is in cycle state i, for i from 0 to NUM_CYC-1 (0 to 6 by default).
- R3: When `op_load` is high at a clock edge, `op_in` is captured as the opcode and `cycle_vec` becomes 1 after that edge. `op_load` takes priority over `instr_end` in the same cycle.
- R4: After a load, each clock edge with neither `op_load` nor `instr_end` high moves the set bit of `cycle_vec` up by one position. This continues until the last state is reached.
- R5: When `instr_end` is high without `op_load` after a load, `cycle_vec` becomes 1 after the edge and the captured opcode is kept.
- R6: In the last state, a clock edge with neither strobe high keeps the token on the last state and sets `overrun`. `overrun` then stays 1 until reset, even through later loads.
- R7: Term k fires when `(opcode & TERM_MASK[k]) == (TERM_VAL[k] & TERM_MASK[k])` and `cycle_vec & TERM_CYC[k]` is nonzero. The fields are packed as follows: `TERM_VAL[k]` and `TERM_MASK[k]` are bits `[k*OP_W +: OP_W]`, and `TERM_CYC[k]` is bits `[k*NUM_CYC +: NUM_CYC]`, where cycle-mask bit i selects state i.
- R8: `ctrl_out[j]` is the OR of `TERM_OUT[k*NUM_CTRL + j]` over all fired terms k. A single term may drive several outputs.
- R9: A term whose mask clears some opcode bits fires for every opcode that agrees with its value on the remaining bits.
- R10: When several terms fire in the same cycle, `ctrl_out` is the bitwise OR of their routing rows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| op_load | input | 1 | Capture `op_in` and restart at state 0 |
| op_in | input | OP_W | Opcode to capture |
| instr_end | input | 1 | Current instruction finishes; return to state 0 |
| cycle_vec | output | NUM_CYC | One-hot current cycle state |
| ctrl_out | output | NUM_CTRL | ORed control lines from fired terms |
| overrun | output | 1 | Sticky flag: an instruction stalled in the last state |

## Verification
On every clock, the assertions check the timer's own rules: the token stays one-hot, it shifts by one or restarts on a strobe, it holds in the last state, and the overrun flag is sticky. They also check that a load captures the opcode. Which control lines come up for a given opcode and cycle is a property of the term table, so only the bench's scenarios can show it. Those scenarios cover don't-care matches across several opcodes, terms that overlap in one cycle, terms that drive several outputs, and the quiet outputs before the first load.

// File: rtl/cpd_pkg.sv
package cpd_pkg;

    localparam int DEF_OP_W     = 8;
    localparam int DEF_NUM_CYC  = 7;
    localparam int DEF_NUM_TERM = 8;
    localparam int DEF_NUM_CTRL = 6;

    // Default term list, entry 0 in the least significant slice.
    localparam logic [DEF_NUM_TERM*DEF_OP_W-1:0] DEF_TERM_VAL =
        {8'h30, 8'h0F, 8'h00, 8'h00, 8'hA5, 8'h01, 8'h80, 8'h00};
    localparam logic [DEF_NUM_TERM*DEF_OP_W-1:0] DEF_TERM_MASK =
        {8'hF0, 8'h0F, 8'h00, 8'h80, 8'hFF, 8'h03, 8'h80, 8'h00};
    localparam logic [DEF_NUM_TERM*DEF_NUM_CYC-1:0] DEF_TERM_CYC =
        {7'h03, 7'h30, 7'h40, 7'h04, 7'h08, 7'h06, 7'h02, 7'h01};
    localparam logic [DEF_NUM_TERM*DEF_NUM_CTRL-1:0] DEF_TERM_OUT =
        {6'h24, 6'h10, 6'h20, 6'h08, 6'h18, 6'h04, 6'h02, 6'h01};

    // What the timer does on a given clock edge.
    typedef enum logic [1:0] {
        EV_IDLE = 2'd0,
        EV_LOAD = 2'd1,
        EV_END  = 2'd2,
        EV_STEP = 2'd3
    } timer_evt_e;

endpackage

// File: rtl/cpd_cycle_timer.sv
module cpd_cycle_timer
    import cpd_pkg::*;
#(
    parameter int NUM_CYC = DEF_NUM_CYC
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               fin,
    output logic [NUM_CYC-1:0] cycle,
    output logic               active,
    output logic               overrun
);

    localparam logic [NUM_CYC-1:0] FIRST_STATE = NUM_CYC'(1);
    localparam int                 LAST_IDX    = NUM_CYC - 1;

    typedef struct packed {
        logic [NUM_CYC-1:0] cyc;
        logic               act;
        logic               ovr;
    } tstate_t;

    tstate_t    s_d, s_q;
    timer_evt_e evt;

    always_comb begin
        s_d = s_q;
        if (load)            evt = EV_LOAD;
        else if (!s_q.act)   evt = EV_IDLE;
        else if (fin)        evt = EV_END;
        else                 evt = EV_STEP;

        case (evt)
            EV_LOAD: begin
                s_d.cyc = FIRST_STATE;
                s_d.act = 1'b1;
            end
            EV_END: begin
                s_d.cyc = FIRST_STATE;
            end
            EV_STEP: begin
                if (s_q.cyc[LAST_IDX]) s_d.ovr = 1'b1;
                else                   s_d.cyc = s_q.cyc << 1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.cyc <= FIRST_STATE;
            s_q.act <= 1'b0;
            s_q.ovr <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cycle   = s_q.cyc;
    assign active  = s_q.act;
    assign overrun = s_q.ovr;

    // R2
    token_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(s_q.cyc) == 1);

    // R3
    load_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (s_q.cyc == FIRST_STATE) && s_q.act);

    // R4
    token_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.act && !load && !fin && !s_q.cyc[LAST_IDX])
        |=> (s_q.cyc == ($past(s_q.cyc) << 1)));

    // R5
    end_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.act && fin && !load) |=> (s_q.cyc == FIRST_STATE));

    // R6
    last_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.act && !load && !fin && s_q.cyc[LAST_IDX])
        |=> (s_q.cyc[LAST_IDX] && s_q.ovr));

    // R6
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.ovr |=> s_q.ovr);

    // R1
    idle_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.act && !load) |=> (s_q.cyc == FIRST_STATE) && !s_q.act);

endmodule

// File: rtl/cpd_opcode_reg.sv
module cpd_opcode_reg
    import cpd_pkg::*;
#(
    parameter int OP_W = DEF_OP_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [OP_W-1:0] op_in,
    output logic [OP_W-1:0] opcode
);

    typedef struct packed {
        logic [OP_W-1:0] op;
    } ostate_t;

    ostate_t o_d, o_q;

    always_comb begin
        o_d = o_q;
        if (load) o_d.op = op_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q.op <= '0;
        else        o_q <= o_d;
    end

    assign opcode = o_q.op;

    // R3
    opcode_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (o_q.op == $past(op_in)));

    // R5
    opcode_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(o_q.op));

endmodule

// File: rtl/cpd_term_match.sv
module cpd_term_match
    import cpd_pkg::*;
#(
    parameter int OP_W      = DEF_OP_W,
    parameter int NUM_CYC   = DEF_NUM_CYC,
    parameter int NUM_TERMS = DEF_NUM_TERM,
    parameter logic [NUM_TERMS*OP_W-1:0]    TERM_VAL  = DEF_TERM_VAL,
    parameter logic [NUM_TERMS*OP_W-1:0]    TERM_MASK = DEF_TERM_MASK,
    parameter logic [NUM_TERMS*NUM_CYC-1:0] TERM_CYC  = DEF_TERM_CYC
) (
    input  logic [OP_W-1:0]      opcode,
    input  logic [NUM_CYC-1:0]   cycle,
    output logic [NUM_TERMS-1:0] fired
);

    for (genvar k = 0; k < NUM_TERMS; k++) begin : g_term
        localparam logic [OP_W-1:0]    VAL_K  = TERM_VAL[k*OP_W +: OP_W];
        localparam logic [OP_W-1:0]    MASK_K = TERM_MASK[k*OP_W +: OP_W];
        localparam logic [NUM_CYC-1:0] CYC_K  = TERM_CYC[k*NUM_CYC +: NUM_CYC];

        logic op_hit;
        logic cyc_hit;

        always_comb begin
            op_hit   = ((opcode ^ VAL_K) & MASK_K) == '0;
            cyc_hit  = |(cycle & CYC_K);
            fired[k] = op_hit & cyc_hit;
        end
    end

endmodule

// File: rtl/cpd_or_plane.sv
module cpd_or_plane
    import cpd_pkg::*;
#(
    parameter int NUM_TERMS = DEF_NUM_TERM,
    parameter int NUM_CTRL  = DEF_NUM_CTRL,
    parameter logic [NUM_TERMS*NUM_CTRL-1:0] TERM_OUT = DEF_TERM_OUT
) (
    input  logic                 enable,
    input  logic [NUM_TERMS-1:0] fired,
    output logic [NUM_CTRL-1:0]  ctrl
);

    for (genvar j = 0; j < NUM_CTRL; j++) begin : g_col
        logic [NUM_TERMS-1:0] column;

        for (genvar k = 0; k < NUM_TERMS; k++) begin : g_row
            assign column[k] = TERM_OUT[k*NUM_CTRL + j];
        end

        assign ctrl[j] = enable & |(fired & column);
    end

endmodule

// File: rtl/cycle_pla_decoder.sv
module cycle_pla_decoder
    import cpd_pkg::*;
#(
    parameter int OP_W      = DEF_OP_W,
    parameter int NUM_CYC   = DEF_NUM_CYC,
    parameter int NUM_TERMS = DEF_NUM_TERM,
    parameter int NUM_CTRL  = DEF_NUM_CTRL,
    parameter logic [NUM_TERMS*OP_W-1:0]     TERM_VAL  = DEF_TERM_VAL,
    parameter logic [NUM_TERMS*OP_W-1:0]     TERM_MASK = DEF_TERM_MASK,
    parameter logic [NUM_TERMS*NUM_CYC-1:0]  TERM_CYC  = DEF_TERM_CYC,
    parameter logic [NUM_TERMS*NUM_CTRL-1:0] TERM_OUT  = DEF_TERM_OUT
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                op_load,
    input  logic [OP_W-1:0]     op_in,
    input  logic                instr_end,
    output logic [NUM_CYC-1:0]  cycle_vec,
    output logic [NUM_CTRL-1:0] ctrl_out,
    output logic                overrun
);

    logic [OP_W-1:0]      opcode;
    logic [NUM_TERMS-1:0] fired;
    logic                 active;

    cpd_cycle_timer #(
        .NUM_CYC (NUM_CYC)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (op_load),
        .fin     (instr_end),
        .cycle   (cycle_vec),
        .active  (active),
        .overrun (overrun)
    );

    cpd_opcode_reg #(
        .OP_W (OP_W)
    ) u_opreg (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (op_load),
        .op_in  (op_in),
        .opcode (opcode)
    );

    cpd_term_match #(
        .OP_W      (OP_W),
        .NUM_CYC   (NUM_CYC),
        .NUM_TERMS (NUM_TERMS),
        .TERM_VAL  (TERM_VAL),
        .TERM_MASK (TERM_MASK),
        .TERM_CYC  (TERM_CYC)
    ) u_terms (
        .opcode (opcode),
        .cycle  (cycle_vec),
        .fired  (fired)
    );

    cpd_or_plane #(
        .NUM_TERMS (NUM_TERMS),
        .NUM_CTRL  (NUM_CTRL),
        .TERM_OUT  (TERM_OUT)
    ) u_plane (
        .enable (active),
        .fired  (fired),
        .ctrl   (ctrl_out)
    );

    // R1
    quiet_before_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (ctrl_out == '0));

    // R8
    no_term_no_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fired == '0) |-> (ctrl_out == '0));

endmodule

// File: tb/test_cycle_pla_decoder.sv
module test_cycle_pla_decoder;

    localparam int NT = 8;
    localparam int NC = 6;
    localparam int CY = 7;

    localparam logic [7:0]    BV [NT] = '{8'h00, 8'h80, 8'h01, 8'hA5, 8'h00, 8'h00, 8'h0F, 8'h30};
    localparam logic [7:0]    BM [NT] = '{8'h00, 8'h80, 8'h03, 8'hFF, 8'h80, 8'h00, 8'h0F, 8'hF0};
    localparam logic [CY-1:0] BC [NT] = '{7'h01, 7'h02, 7'h06, 7'h08, 7'h04, 7'h40, 7'h30, 7'h03};
    localparam logic [NC-1:0] BO [NT] = '{6'h01, 6'h02, 6'h04, 6'h18, 6'h08, 6'h20, 6'h10, 6'h24};

    localparam logic [NT*8-1:0]  PV = {BV[7], BV[6], BV[5], BV[4], BV[3], BV[2], BV[1], BV[0]};
    localparam logic [NT*8-1:0]  PM = {BM[7], BM[6], BM[5], BM[4], BM[3], BM[2], BM[1], BM[0]};
    localparam logic [NT*CY-1:0] PC = {BC[7], BC[6], BC[5], BC[4], BC[3], BC[2], BC[1], BC[0]};
    localparam logic [NT*NC-1:0] PO = {BO[7], BO[6], BO[5], BO[4], BO[3], BO[2], BO[1], BO[0]};

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n     = 1'b0;
    logic          op_load   = 1'b0;
    logic          instr_end = 1'b0;
    logic [7:0]    op_in     = 8'h00;
    logic [CY-1:0] cycle_vec;
    logic [NC-1:0] ctrl_out;
    logic          overrun;

    cycle_pla_decoder #(
        .OP_W (8), .NUM_CYC (CY), .NUM_TERMS (NT), .NUM_CTRL (NC),
        .TERM_VAL (PV), .TERM_MASK (PM), .TERM_CYC (PC), .TERM_OUT (PO)
    ) i_cycle_pla_decoder (
        .clk (clk), .rst_n (rst_n), .op_load (op_load), .op_in (op_in),
        .instr_end (instr_end), .cycle_vec (cycle_vec), .ctrl_out (ctrl_out),
        .overrun (overrun)
    );

    int n_tests = 0;
    int n_fail  = 0;

    typedef struct {
        int            cyc;
        logic [NC-1:0] ctrl;
        bit            ovr;
        string         req;
    } exp_t;

    exp_t exp_q[$];

    int         m_cyc = 0;
    bit         m_act = 1'b0;
    bit         m_ovr = 1'b0;
    logic [7:0] m_op  = 8'h00;

    function automatic logic [NC-1:0] model_ctrl(logic [7:0] op, int cyc);
        logic [NC-1:0] r = '0;
        for (int k = 0; k < NT; k++) begin
            if (((op & BM[k]) == (BV[k] & BM[k])) && BC[k][cyc]) r |= BO[k];
        end
        return r;
    endfunction

    task automatic chk(bit ok, string req, string what, longint act, longint expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic report_and_end();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // Driver: apply one clock of stimulus, update the model, queue the result.
    task automatic step(bit ld, logic [7:0] op, bit en, string req);
        exp_t e;
        @(negedge clk);
        op_load   = ld;
        op_in     = op;
        instr_end = en;
        if (ld) begin
            m_op  = op;
            m_cyc = 0;
            m_act = 1'b1;
        end else if (m_act) begin
            if (en)                m_cyc = 0;
            else if (m_cyc == CY-1) m_ovr = 1'b1;
            else                   m_cyc++;
        end
        @(posedge clk);
        e.cyc  = m_cyc;
        e.ctrl = m_act ? model_ctrl(m_op, m_cyc) : '0;
        e.ovr  = m_ovr;
        e.req  = req;
        exp_q.push_back(e);
    endtask

    // Monitor: compare at the falling edge after each queued result.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            logic [CY-1:0] cv;
            e  = exp_q.pop_front();
            cv = CY'(1) << e.cyc;
            chk(cycle_vec == cv, e.req, "cycle_vec", cycle_vec, cv);
            chk(ctrl_out == e.ctrl, e.req, "ctrl_out", ctrl_out, e.ctrl);
            chk(overrun == e.ovr, e.req, "overrun", overrun, e.ovr);
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report_and_end();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(cycle_vec == CY'(1), "R1", "reset cycle_vec", cycle_vec, 1);
        chk(ctrl_out == '0, "R1", "reset ctrl_out", ctrl_out, 0);
        chk(overrun == 1'b0, "R1", "reset overrun", overrun, 0);
        rst_n = 1'b1;

        // R1: no load yet, so the end strobe is ignored and outputs stay quiet
        step(0, 8'hFF, 0, "R1");
        step(0, 8'hFF, 1, "R1");
        step(0, 8'h00, 0, "R1");

        // R3 R4 R8 R10: exact-match opcode walks through its cycles
        step(1, 8'hA5, 0, "R3");
        for (int i = 0; i < 4; i++) step(0, 8'h00, 0, "R4");
        // R5: early end keeps the opcode, decode restarts at state 0
        step(0, 8'h00, 1, "R5");
        step(0, 8'h00, 0, "R5");
        step(0, 8'h00, 0, "R5");

        // R6 R10: overlapping terms, then overrun and hold in the last state
        step(1, 8'h35, 0, "R10");
        for (int i = 0; i < 6; i++) step(0, 8'h00, 0, "R10");
        step(0, 8'h00, 0, "R6");
        step(0, 8'h00, 0, "R6");
        // R6: sticky through a new load; R3: load wins over end
        step(1, 8'h0F, 1, "R3");
        for (int i = 0; i < 6; i++) step(0, 8'h00, 0, "R7");

        // R9: masked bits are don't-care across several opcodes
        step(1, 8'h01, 0, "R9");
        step(0, 8'h00, 0, "R9");
        step(1, 8'hFD, 0, "R9");
        step(0, 8'h00, 0, "R9");
        step(0, 8'h00, 0, "R9");
        step(1, 8'h7E, 0, "R9");
        step(0, 8'h00, 0, "R9");
        step(0, 8'h00, 0, "R9");
        step(0, 8'h00, 1, "R8");

        @(negedge clk);
        op_load   = 1'b0;
        instr_end = 1'b0;
        while (exp_q.size() > 0) @(posedge clk);
        @(posedge clk);
        report_and_end();
    end

endmodule